// File: doc/BRIEF.md
# Latency-Matched Third-Order Cascaded Sigma-Delta Ratio Generator

This block sits between the frequency-word logic of a fractional-N synthesizer and its multi-modulus divider. On every divider output cycle it accepts a requested division ratio as two parts: an integer part and an unsigned fraction of `FRAC_W` bits. It emits one instantaneous integer ratio per cycle. Three first-order accumulators are chained so that each one integrates the residue of the stage before it. Their carries are combined with first- and second-order differencing, which pushes the quantisation noise up in frequency. Averaged over time, the emitted ratios equal `int + frac / 2^FRAC_W`.

The accumulator chain is pipelined, so a fraction takes three register stages to produce its first shaped carry. The integer part passes through a delay line of the same depth. It therefore meets its own fraction at the output adder, and a ramp step that changes both parts at once does not produce a transient wrong ratio. The sum then passes through `OUT_STAGES` retiming registers before it leaves the block.

The block produces one ratio on every clock and its inputs are sampled on every clock. There is no handshake and no back-pressure, because the divider consumes exactly one ratio per cycle of the clock that drives this block.

Top module: `fracn_mash_ratio`

## Requirements
- R1: While `rst_n` is low, `ratio_out` is 0 and every accumulator, carry and delay register is cleared.
- R2: A value presented on `int_in` before clock edge k first appears on `ratio_out` after edge k+3+OUT_STAGES-1 (3+OUT_STAGES registers in total). Before that, the output still shows the previous integer (0 right after reset).
- R3: With `frac_in` held at 0 since reset, `ratio_out` equals the aligned integer on every cycle, with no noise term.
- R4: Each output equals the aligned integer plus a shaping term in the range -3 to +4. This assumes `int_in` is between 3 and 2^INT_W-1, so the result never wraps.
- R5: For inputs held constant from reset, the sum of the first 2^FRAC_W outputs equals 2^FRAC_W·int + frac + e, with e between -1 and +2.
- R6: Integer and fraction applied at the same edge reach the output together. From reset with fraction 2^FRAC_W-1 and integer B, the first two outputs are B and B+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider output clock; one ratio per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| int_in | input | INT_W | Integer part of the requested ratio (3 to 2^INT_W-1) |
| frac_in | input | FRAC_W | Fractional part, unsigned, weight 2^-FRAC_W |
| ratio_out | output | INT_W+1 | Instantaneous divide ratio for the divider |

## Verification
The bench builds the block with FRAC_W=8, INT_W=6 and OUT_STAGES=2. This makes the full accumulator period only 256 cycles, so every one of the 256 fraction values can be run from reset through a complete period. Each run checks the exact sum bound and the per-cycle range, and pairs each fraction with a different integer. The two-stage retiming makes the integer-delay latency 5 edges, which the integer step test measures exactly. The all-ones fraction drives every carry on the second cycle, so it pins down coherent alignment.

// File: rtl/fracn_mash_pkg.sv
package fracn_mash_pkg;
  // Number of cascaded first-order stages.
  localparam int MASH_ORDER = 3;
  // Shaping term spans -3..+4, so 4 signed bits are enough.
  localparam int NOISE_W = 4;
  typedef logic signed [NOISE_W-1:0] noise_t;
endpackage

// File: rtl/fracn_acc_stage.sv
module fracn_acc_stage #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] addend,
  output logic [W-1:0] acc,
  output logic         carry
);
  logic [W:0] sum_w;
  logic       primed;

  assign sum_w = {1'b0, acc} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      carry  <= 1'b0;
      primed <= 1'b0;
    end else begin
      acc    <= sum_w[W-1:0];
      carry  <= sum_w[W];
      primed <= 1'b1;
    end
  end

  // R5
  acc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && carry) |-> (acc < $past(acc)));

  // R5
  acc_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !carry) |-> (acc >= $past(acc)));
endmodule

// File: rtl/fracn_noise_shaper.sv
module fracn_noise_shaper
  import fracn_mash_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] carry_in,
  output noise_t     noise
);
  // Stage 1 carry is two cycles early, stage 2 one cycle early.
  logic c1_d1, c1_d2;
  logic c2_d1, c2_d2;
  logic c3_d1, c3_d2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1_d1 <= 1'b0;
      c1_d2 <= 1'b0;
      c2_d1 <= 1'b0;
      c2_d2 <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else begin
      c1_d1 <= carry_in[0];
      c1_d2 <= c1_d1;
      c2_d1 <= carry_in[1];
      c2_d2 <= c2_d1;
      c3_d1 <= carry_in[2];
      c3_d2 <= c3_d1;
    end
  end

  noise_t t1, t2, t3;
  always_comb begin
    t1    = noise_t'({3'b000, c1_d2});
    t2    = noise_t'({3'b000, c2_d1}) - noise_t'({3'b000, c2_d2});
    t3    = noise_t'({3'b000, carry_in[2]}) - noise_t'({2'b00, c3_d1, 1'b0})
          + noise_t'({3'b000, c3_d2});
    noise = t1 + t2 + t3;
  end
endmodule

// File: rtl/fracn_int_delay.sv
module fracn_int_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] tap [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) tap[i] <= '0;
      else if (i == 0) tap[i] <= din;
      else tap[i] <= tap[(i == 0) ? 0 : i - 1];
    end
  end

  assign dout = tap[DEPTH-1];
endmodule

// File: rtl/fracn_mash_ratio.sv
module fracn_mash_ratio
  import fracn_mash_pkg::*;
#(
  parameter int FRAC_W     = 20,
  parameter int INT_W      = 8,
  parameter int OUT_STAGES = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INT_W-1:0]   int_in,
  input  logic [FRAC_W-1:0]  frac_in,
  output logic [INT_W:0]     ratio_out
);
  localparam int OUT_W   = INT_W + 1;
  localparam int ALIGN_D = MASH_ORDER;

  // Accumulator cascade: each stage integrates the residue of the previous.
  logic [FRAC_W-1:0] acc_v   [MASH_ORDER];
  logic [FRAC_W-1:0] addend_v[MASH_ORDER];
  logic [MASH_ORDER-1:0] carry_v;

  for (genvar k = 0; k < MASH_ORDER; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign addend_v[k] = frac_in;
    end else begin : g_tail
      assign addend_v[k] = acc_v[k-1];
    end
    fracn_acc_stage #(.W(FRAC_W)) stage_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .addend (addend_v[k]),
      .acc    (acc_v[k]),
      .carry  (carry_v[k])
    );
  end

  noise_t noise;
  fracn_noise_shaper shaper_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .carry_in (carry_v),
    .noise    (noise)
  );

  // Integer part delayed by the depth of the accumulator pipeline.
  logic [INT_W-1:0] int_al;
  fracn_int_delay #(.W(INT_W), .DEPTH(ALIGN_D)) align_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (int_in),
    .dout  (int_al)
  );

  logic [INT_W+1:0] mix;
  assign mix = {2'b00, int_al} + {{(INT_W+2-NOISE_W){noise[NOISE_W-1]}}, noise};

  // Retiming registers toward the divider control.
  logic [OUT_W-1:0] rt [OUT_STAGES];
  for (genvar s = 0; s < OUT_STAGES; s++) begin : g_retime
    always_ff @(posedge clk) begin
      if (!rst_n) rt[s] <= '0;
      else if (s == 0) rt[s] <= mix[OUT_W-1:0];
      else rt[s] <= rt[(s == 0) ? 0 : s - 1];
    end
  end
  assign ratio_out = rt[OUT_STAGES-1];

  // Cycles since reset, saturating; used only to gate the checks below.
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  int_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (int_al == $past(int_in, 3)));

  // R4
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0) |-> ((int'(rt[0]) - int'($past(int_al)) >= -3) &&
                       (int'(rt[0]) - int'($past(int_al)) <= 4)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    (age == 2'd0 && !rst_n) |=> (rt[0] == '0 || rst_n));
endmodule

// File: tb/fracn_mash_ratio_tb.sv
module fracn_mash_ratio_tb_top;
  localparam int FW  = 8;
  localparam int IW  = 6;
  localparam int OS  = 2;
  localparam int M   = 1 << FW;
  localparam int LAT = 3 + OS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] int_in = '0;
  logic [FW-1:0] frac_in = '0;
  logic [IW:0]   ratio_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fracn_mash_ratio #(.FRAC_W(FW), .INT_W(IW), .OUT_STAGES(OS)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_in    (int_in),
    .frac_in   (frac_in),
    .ratio_out (ratio_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Applies reset with inputs set; on return the next rising edge is the first active one.
  task automatic do_reset(input int b, input int f);
    @(negedge clk);
    rst_n   = 1'b0;
    int_in  = IW'(b);
    frac_in = FW'(f);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int sum, lo, hi, b;
    // R1: output cleared during reset
    @(negedge clk);
    int_in = 6'd33; frac_in = 8'd77;
    repeat (3) @(negedge clk);
    check("R1 reset output", int'(ratio_out), 0);

    // R6: coherent arrival with all-ones fraction
    do_reset(10, M - 1);
    repeat (LAT - 1) @(negedge clk);
    check("R6 before arrival", int'(ratio_out), 0);
    @(negedge clk);
    check("R6 first output", int'(ratio_out), 10);
    @(negedge clk);
    check("R6 second output", int'(ratio_out), 13);

    // R2: integer-only step with zero fraction
    do_reset(12, 0);
    repeat (LAT + 3) @(negedge clk);
    check("R2 steady", int'(ratio_out), 12);
    int_in = 6'd40;
    repeat (LAT - 1) @(negedge clk);
    check("R2 old value held", int'(ratio_out), 12);
    @(negedge clk);
    check("R2 new value", int'(ratio_out), 40);

    // R3, R4, R5: sweep every fraction over one full period
    for (int f = 0; f < M; f++) begin
      b = 3 + (f % 61);
      do_reset(b, f);
      repeat (LAT - 1) @(negedge clk);
      if (f % 32 == 0) check("R2 fill", int'(ratio_out), 0);
      sum = 0; lo = 1000; hi = -1000;
      for (int i = 0; i < M; i++) begin
        @(negedge clk);
        sum += int'(ratio_out);
        if (int'(ratio_out) - b < lo) lo = int'(ratio_out) - b;
        if (int'(ratio_out) - b > hi) hi = int'(ratio_out) - b;
      end
      if (f == 0) begin
        check("R3 zero fraction min", lo, 0);
        check("R3 zero fraction max", hi, 0);
      end
      check("R4 range low ok", int'(lo >= -3), 1);
      check("R4 range high ok", int'(hi <= 4), 1);
      lo = sum - M * b - f;
      check("R5 period sum error in [-1,2]", int'(lo >= -1 && lo <= 2), 1);
      if (!(lo >= -1 && lo <= 2))
        $display("  R5 detail: f=%0d sum=%0d expected~%0d", f, sum, M * b + f);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule